// File: doc/BRIEF.md
# Outbound Address Window Translator

This block turns a local processor bus address into a PCI bus address. Software programs a small bank of 32-bit registers that describe a set of outbound windows. Two of the windows are complete: each has a 64-bit local base, a 64-bit PCI base and a 32-bit size/attribute word. A third window holds only a size/attribute word and never takes part in translation. An address presented with a valid strobe is compared against every enabled window at once. The result (a hit flag, the index of the winning window and the translated address) is registered and appears one cycle later.

A window's span comes from its size word. Bit 0 is the enable. The rest of the word is a mask: the span is the 32-bit two's complement of the word with bit 0 cleared. A mask of zero would give a span of zero, so the block uses 0xFFFFFFFF instead. Forwarding the transaction, ordering and any bus protocol engine are left to the surrounding logic.

Top module: `obw_xlate`

## Requirements
- R1: After reset every register reads 0, so every window is disabled and no address hits.
- R2: A 64-bit base is written as two 32-bit halves. Writing one half leaves the other half unchanged. A read of the high half returns bits 63:32 and a read of the low half returns bits 31:0.
- R3: A window whose size word has bit 0 clear never matches, whatever its bases are.
- R4: An enabled window's span is the 32-bit two's complement of its size word with bit 0 cleared. An address hits when it is at least the local base and below the local base plus the span, so base+span-1 hits and base+span misses.
- R5: When the size word with bit 0 cleared is zero, the span is 0xFFFFFFFF. Base+0xFFFFFFFE hits and base+0xFFFFFFFF misses.
- R6: On a hit the output address equals the window's PCI base plus the offset of the input address from the window's local base, in 64 bits.
- R7: When several enabled windows match, the lowest-numbered one is reported.
- R8: out_valid, out_hit, out_win and out_addr are registered one cycle after in_valid. A cycle without in_valid gives out_valid=0 and out_hit=0 on the following cycle.
- R9: The size word of window 2 at byte offset 0x90 can be written and read back, but it never produces a hit; out_win is always 0 or 1.
- R10: A write to an offset not listed in R11 changes no register, and a read from such an offset returns 0.
- R11: Register byte offsets. Window 0: local low 0x68, local high 0x6C, size 0x70, PCI low 0x74, PCI high 0x78. Window 1: the same five registers at 0x7C, 0x80, 0x84, 0x88, 0x8C. Window 2: size at 0x90.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside the block |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte offset, used for both reads and writes |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr (combinational) |
| in_valid | input | 1 | Marks in_addr as valid in this cycle |
| in_addr | input | 64 | Local address to translate |
| out_valid | output | 1 | Registered copy of in_valid |
| out_hit | output | 1 | Some enabled window matched |
| out_win | output | 2 | Index of the winning window |
| out_addr | output | 64 | Translated PCI address |

## Verification
The hardest cases to reach from the ports are the two edges of the span. The first is the forced maximum span, whose upper limit lies just under 4 GiB above the base. The second is a pair of overlapping windows, where priority decides the result. The stimulus programs window 1 high in the 64-bit space with a size word of only the enable bit. It then probes the addresses one below and exactly at base+0xFFFFFFFF. For priority, it places a 64 KiB window 1 over a 4 KiB window 0 and sends addresses inside both, inside only the larger one, and on the exact limits of the smaller one.

// File: rtl/obw_pkg.sv
package obw_pkg;
  localparam int REG_W   = 32;
  localparam int N_FIELD = 5;
  typedef enum logic [2:0] {
    FLD_LOC_LO = 3'd0,
    FLD_LOC_HI = 3'd1,
    FLD_SIZE   = 3'd2,
    FLD_PCI_LO = 3'd3,
    FLD_PCI_HI = 3'd4
  } fld_e;
endpackage

// File: rtl/obw_regbank.sv
module obw_regbank
  import obw_pkg::*;
#(
  parameter int AW       = 64,
  parameter int N_FULL   = 2,
  parameter int N_SZONLY = 1,
  parameter int OFS_W    = 8,
  parameter int FIRST_OFS = 'h68
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_wr,
  input  logic [OFS_W-1:0]             cfg_addr,
  input  logic [REG_W-1:0]             cfg_wdata,
  output logic [REG_W-1:0]             cfg_rdata,
  output logic [N_FULL-1:0][AW-1:0]    loc_base,
  output logic [N_FULL-1:0][AW-1:0]    pci_base,
  output logic [N_FULL-1:0][REG_W-1:0] size_word
);
  localparam int STRIDE  = 4 * N_FIELD;
  localparam int SZO_OFS = FIRST_OFS + N_FULL * STRIDE;

  logic [N_FULL-1:0][AW-1:0]      la_q, la_d, pa_q, pa_d;
  logic [N_FULL-1:0][REG_W-1:0]   sz_q, sz_d;
  logic [N_SZONLY-1:0][REG_W-1:0] so_q, so_d;

  always_comb begin
    la_d      = la_q;
    pa_d      = pa_q;
    sz_d      = sz_q;
    so_d      = so_q;
    cfg_rdata = '0;
    for (int w = 0; w < N_FULL; w++) begin
      for (int f = 0; f < N_FIELD; f++) begin
        if (cfg_addr == OFS_W'(FIRST_OFS + w * STRIDE + 4 * f)) begin
          case (fld_e'(f))
            FLD_LOC_LO: begin
              cfg_rdata = la_q[w][31:0];
              if (cfg_wr) la_d[w][31:0] = cfg_wdata;
            end
            FLD_LOC_HI: begin
              cfg_rdata = la_q[w][AW-1:32];
              if (cfg_wr) la_d[w][AW-1:32] = cfg_wdata;
            end
            FLD_SIZE: begin
              cfg_rdata = sz_q[w];
              if (cfg_wr) sz_d[w] = cfg_wdata;
            end
            FLD_PCI_LO: begin
              cfg_rdata = pa_q[w][31:0];
              if (cfg_wr) pa_d[w][31:0] = cfg_wdata;
            end
            default: begin
              cfg_rdata = pa_q[w][AW-1:32];
              if (cfg_wr) pa_d[w][AW-1:32] = cfg_wdata;
            end
          endcase
        end
      end
    end
    for (int s = 0; s < N_SZONLY; s++) begin
      if (cfg_addr == OFS_W'(SZO_OFS + 4 * s)) begin
        cfg_rdata = so_q[s];
        if (cfg_wr) so_d[s] = cfg_wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      la_q <= '0;
      pa_q <= '0;
      sz_q <= '0;
      so_q <= '0;
    end else if (cfg_wr) begin
      la_q <= la_d;
      pa_q <= pa_d;
      sz_q <= sz_d;
      so_q <= so_d;
    end
  end

  assign loc_base  = la_q;
  assign pci_base  = pa_q;
  assign size_word = sz_q;

  // R2: writing the low half of window 0's local base keeps the high half
  a_r2_hi_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_addr == OFS_W'(FIRST_OFS)) |=> $stable(la_q[0][AW-1:32]));

  // R10: a write to an unlisted offset leaves every register alone
  a_r10_unmapped_wr: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_addr == OFS_W'(SZO_OFS + 4 * N_SZONLY))
      |=> ($stable(la_q) && $stable(pa_q) && $stable(sz_q) && $stable(so_q)));
endmodule

// File: rtl/obw_win_match.sv
module obw_win_match
  import obw_pkg::*;
#(
  parameter int AW = 64
) (
  input  logic [AW-1:0]    in_addr,
  input  logic [AW-1:0]    loc_base,
  input  logic [AW-1:0]    pci_base,
  input  logic [REG_W-1:0] size_word,
  output logic             match,
  output logic [AW-1:0]    xaddr
);
  logic [REG_W-1:0] mask, neg, span;
  logic [AW:0]      limit;

  always_comb begin
    mask  = size_word & ~REG_W'(1);
    neg   = ~mask + REG_W'(1);
    span  = (neg == '0) ? {REG_W{1'b1}} : neg;
    limit = {1'b0, loc_base} + (AW + 1)'(span);
    match = size_word[0] && (in_addr >= loc_base) && ({1'b0, in_addr} < limit);
    xaddr = pci_base + (in_addr - loc_base);
  end
endmodule

// File: rtl/obw_prio_sel.sv
module obw_prio_sel #(
  parameter int AW    = 64,
  parameter int N     = 2,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0]         match_vec,
  input  logic [N-1:0][AW-1:0] xaddr_vec,
  output logic                 any,
  output logic [IDX_W-1:0]     idx,
  output logic [AW-1:0]        xaddr
);
  always_comb begin
    any   = 1'b0;
    idx   = '0;
    xaddr = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match_vec[i]) begin
        any   = 1'b1;
        idx   = IDX_W'(i);
        xaddr = xaddr_vec[i];
      end
    end
  end
endmodule

// File: rtl/obw_xlate.sv
module obw_xlate
  import obw_pkg::*;
#(
  parameter int AW       = 64,
  parameter int N_FULL   = 2,
  parameter int N_SZONLY = 1,
  parameter int OFS_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [7:0]       cfg_addr,
  input  logic [31:0]      cfg_wdata,
  output logic [31:0]      cfg_rdata,
  input  logic             in_valid,
  input  logic [63:0]      in_addr,
  output logic             out_valid,
  output logic             out_hit,
  output logic [1:0]       out_win,
  output logic [63:0]      out_addr
);
  localparam int N_WIN = N_FULL + N_SZONLY;
  localparam int IDX_W = (N_WIN > 1) ? $clog2(N_WIN) : 1;

  logic [1:0] rst_sync;
  logic       rst_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ns = rst_sync[1];

  logic [N_FULL-1:0][AW-1:0]    loc_base, pci_base, xaddr_vec;
  logic [N_FULL-1:0][REG_W-1:0] size_word;
  logic [N_FULL-1:0]            match_vec, en_vec;
  logic                         any;
  logic [IDX_W-1:0]             sel_idx;
  logic [AW-1:0]                sel_addr;

  obw_regbank #(.AW(AW), .N_FULL(N_FULL), .N_SZONLY(N_SZONLY), .OFS_W(OFS_W)) u_regs (
    .clk(clk), .rst_n(rst_ns), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .loc_base(loc_base), .pci_base(pci_base), .size_word(size_word)
  );

  for (genvar w = 0; w < N_FULL; w++) begin : g_win
    obw_win_match #(.AW(AW)) u_match (
      .in_addr(in_addr), .loc_base(loc_base[w]), .pci_base(pci_base[w]),
      .size_word(size_word[w]), .match(match_vec[w]), .xaddr(xaddr_vec[w])
    );
    assign en_vec[w] = size_word[w][0];
  end

  obw_prio_sel #(.AW(AW), .N(N_FULL), .IDX_W(IDX_W)) u_sel (
    .match_vec(match_vec), .xaddr_vec(xaddr_vec),
    .any(any), .idx(sel_idx), .xaddr(sel_addr)
  );

  logic             vld_d, hit_d;
  logic [IDX_W-1:0] win_q;
  logic [AW-1:0]    addr_q;

  always_comb begin
    vld_d = in_valid;
    hit_d = in_valid & any;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      out_valid <= 1'b0;
      out_hit   <= 1'b0;
    end else begin
      out_valid <= vld_d;
      out_hit   <= hit_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      win_q  <= '0;
      addr_q <= '0;
    end else if (in_valid) begin
      win_q  <= sel_idx;
      addr_q <= sel_addr;
    end
  end

  assign out_win  = 2'(win_q);
  assign out_addr = addr_q;

  // R8: the result follows in_valid by exactly one cycle
  a_r8_valid_lag: assert property (@(posedge clk) disable iff (!rst_ns)
    in_valid |=> out_valid);
  a_r8_idle: assert property (@(posedge clk) disable iff (!rst_ns)
    !in_valid |=> (!out_valid && !out_hit));
  // R3: with every window disabled nothing hits
  a_r3_disabled: assert property (@(posedge clk) disable iff (!rst_ns)
    (in_valid && en_vec == '0) |=> !out_hit);
  // R7: a match on window 0 always wins
  a_r7_low_wins: assert property (@(posedge clk) disable iff (!rst_ns)
    (in_valid && match_vec[0]) |=> (out_hit && out_win == 2'd0));
  // R9: the size-only window is never reported
  a_r9_no_szonly: assert property (@(posedge clk) disable iff (!rst_ns)
    out_hit |-> (out_win < 2'(N_FULL)));
endmodule

// File: tb/sim_obw_xlate.sv
`timescale 1ns/1ps
module sim_obw_xlate;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr;
  logic [7:0]  cfg_addr;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic        in_valid;
  logic [63:0] in_addr;
  logic        out_valid, out_hit;
  logic [1:0]  out_win;
  logic [63:0] out_addr;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  obw_xlate u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .in_valid(in_valid),
    .in_addr(in_addr), .out_valid(out_valid), .out_hit(out_hit),
    .out_win(out_win), .out_addr(out_addr)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] ofs, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = ofs; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd(input string req, input logic [7:0] ofs, input logic [31:0] exp);
    @(negedge clk);
    cfg_addr = ofs;
    #1;
    chk(req, {32'h0, cfg_rdata}, {32'h0, exp});
  endtask

  task automatic xl(input string req, input logic [63:0] a, input logic hit,
                    input logic [1:0] win, input logic [63:0] pa);
    @(negedge clk);
    in_valid = 1'b1; in_addr = a;
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " valid"}, {63'h0, out_valid}, 64'h1);
    chk({req, " hit"}, {63'h0, out_hit}, {63'h0, hit});
    if (hit) begin
      chk({req, " win"}, {62'h0, out_win}, {62'h0, win});
      chk({req, " addr"}, out_addr, pa);
    end
  endtask

  task automatic t_reset;
    for (int i = 0; i < 11; i++) rd("R1 reset read", 8'(8'h68 + 4 * i), 32'h0);
    xl("R1 reset miss", 64'h0, 1'b0, 2'd0, 64'h0);
  endtask

  task automatic t_halves;
    wr(8'h68, 32'h1111_0000);
    wr(8'h6C, 32'h0000_0002);
    rd("R2 low", 8'h68, 32'h1111_0000);
    rd("R2 high", 8'h6C, 32'h0000_0002);
    wr(8'h6C, 32'h0000_0000);
    rd("R2 low kept", 8'h68, 32'h1111_0000);
    wr(8'h68, 32'h0000_1000);
    rd("R2 high kept", 8'h6C, 32'h0);
    wr(8'h78, 32'h0000_0005);
    wr(8'h74, 32'h0000_0000);
    rd("R2 pci high kept", 8'h78, 32'h5);
  endtask

  task automatic t_window0;
    wr(8'h70, 32'hFFFF_F000);
    xl("R3 disabled", 64'h1000, 1'b0, 2'd0, 64'h0);
    wr(8'h70, 32'hFFFF_F001);
    rd("R11 size0", 8'h70, 32'hFFFF_F001);
    xl("R4 base hit", 64'h1000, 1'b1, 2'd0, 64'h5_0000_0000);
    xl("R6 offset", 64'h1010, 1'b1, 2'd0, 64'h5_0000_0010);
    xl("R4 last hit", 64'h1FFF, 1'b1, 2'd0, 64'h5_0000_0FFF);
    xl("R4 limit miss", 64'h2000, 1'b0, 2'd0, 64'h0);
    xl("R4 below miss", 64'h0FFF, 1'b0, 2'd0, 64'h0);
  endtask

  task automatic t_maxspan;
    wr(8'h7C, 32'h0);
    wr(8'h80, 32'h1);
    wr(8'h88, 32'hA000_0000);
    wr(8'h8C, 32'h7);
    wr(8'h84, 32'h0000_0001);
    xl("R5 max last hit", 64'h1_FFFF_FFFE, 1'b1, 2'd1, 64'h8_9FFF_FFFE);
    xl("R5 max limit miss", 64'h1_FFFF_FFFF, 1'b0, 2'd0, 64'h0);
    xl("R6 win1 base", 64'h1_0000_0000, 1'b1, 2'd1, 64'h7_A000_0000);
  endtask

  task automatic t_overlap;
    wr(8'h80, 32'h0);
    wr(8'h8C, 32'h0);
    wr(8'h88, 32'h9000_0000);
    wr(8'h84, 32'hFFFF_0001);
    xl("R7 both match", 64'h1010, 1'b1, 2'd0, 64'h5_0000_0010);
    xl("R7 only win1", 64'h3000, 1'b1, 2'd1, 64'h9000_3000);
    xl("R7 edge of win0", 64'h2000, 1'b1, 2'd1, 64'h9000_2000);
    xl("R7 low win1", 64'h0FFF, 1'b1, 2'd1, 64'h9000_0FFF);
  endtask

  task automatic t_szonly;
    wr(8'h90, 32'hFFFF_FFFF);
    rd("R9 size-only readback", 8'h90, 32'hFFFF_FFFF);
    wr(8'h70, 32'hFFFF_F000);
    wr(8'h84, 32'hFFFF_0000);
    xl("R9 no hit", 64'h1010, 1'b0, 2'd0, 64'h0);
    xl("R3 both disabled", 64'h3000, 1'b0, 2'd0, 64'h0);
  endtask

  task automatic t_unmapped;
    wr(8'h94, 32'hDEAD_BEEF);
    rd("R10 read unmapped", 8'h94, 32'h0);
    wr(8'h64, 32'h1234_5678);
    rd("R10 read below", 8'h64, 32'h0);
    rd("R10 size0 kept", 8'h70, 32'hFFFF_F000);
    rd("R10 size-only kept", 8'h90, 32'hFFFF_FFFF);
  endtask

  task automatic t_idle;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    chk("R8 idle valid", {63'h0, out_valid}, 64'h0);
    chk("R8 idle hit", {63'h0, out_hit}, 64'h0);
  endtask

  initial begin
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    in_valid = 1'b0; in_addr = '0;
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", {63'h0, out_valid}, 64'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_halves();
    t_window0();
    t_maxspan();
    t_overlap();
    t_szonly();
    t_unmapped();
    t_idle();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule